// File: doc/BRIEF.md
# Set-Associative Longest-Prefix Lookup Engine

This block resolves the forwarding decision for a 32-bit destination address at a rate of one lookup per clock. The index of a hash-table row comes from an external hasher. The engine drives the read address of an external synchronous table memory. It receives back a whole row of entries in one access and compares every entry of that row against the address in parallel. Each comparison covers only the entry's prefix length, so the stored bits past that length are don't-care.

Prefixes that could not be placed in the hashed table sit in a small victim array. The victim array is presented to the engine as a flat vector, and its entries are searched in the same cycle as the row. A two-level longest-prefix arbiter merges both sets of candidates. The engine returns the winning next hop, a hit flag and the matched length. When nothing matches, it returns a configurable default next hop. Writing the table and the victim array is done elsewhere.

The pipeline has three stages: index, memory read, then compare and select. A new request may enter on every clock.

Top module: `lpm_lookup_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `res_valid`, `res_hit` and `mem_rd_en` are 0.
- R2: A request sampled with `req_valid`=1 produces `mem_rd_en`=1 with `mem_rd_row` equal to its `req_row` one cycle later. It produces exactly one `res_valid` pulse three cycles after the request. Requests may be issued on consecutive cycles.
- R3: Each entry is 47 bits wide. Bit 46 is the valid flag, bits 45:40 hold the prefix length, bits 39:8 hold the prefix and bits 7:0 hold the next hop. Way w of a row occupies bits [47w+46:47w] of `mem_rd_data`, and victim slot v occupies the same position within `victim_entries`.
- R4: An entry matches when it is valid and the top `len` bits of its prefix equal the top `len` bits of the address. The stored prefix bits below that length do not affect the result.
- R5: Among matching row entries, the one with the greatest length wins. If lengths are equal, the lowest way wins.
- R6: Victim entries are searched on every lookup, with the lowest slot winning among victims of equal length. A victim match that is longer than the best row match, or that occurs with no row match, supplies the result.
- R7: When the best victim match and the best row match have the same length, the victim's next hop is returned.
- R8: On a miss, `res_hit`=0, `res_len`=0 and `res_hop` equals `DEFAULT_HOP`.
- R9: An entry with its valid flag clear, or with a length above 32, never matches.
- R10: A valid entry of length 0 matches every address and reports `res_len`=0 with `res_hit`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup request is present |
| req_addr | input | 32 | Destination address to resolve |
| req_row | input | ROW_BITS | Table row index from the hasher |
| mem_rd_en | output | 1 | Table memory read strobe |
| mem_rd_row | output | ROW_BITS | Table memory row address |
| mem_rd_data | input | WAYS*47 | Row returned by the memory one cycle after the strobe |
| victim_entries | input | VICTIMS*47 | Current contents of the victim array |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Some entry matched |
| res_len | output | 6 | Length of the winning prefix |
| res_hop | output | 8 | Next hop of the winner, or the default on a miss |

## Verification
The bench first loads one row with directed entries. These include two equal-length matches in adjacent ways, a prefix whose stored low bits are nonzero, an entry that is valid but has length 40, and a default route of length 0. A victim of equal length and a longer victim are then added. A design that broke these ties the wrong way would return hop 3 instead of 2, or the row hop instead of the victim hop. A design that compared unmasked bits would miss the don't-care prefix, and one that accepted out-of-range lengths would report length 40. Back-to-back random streams with bubbles compare every result against an arithmetic shift-compare model, which exposes a misaligned pipeline stage as results carrying a neighbour's next hop or landing in the wrong cycle.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

    localparam int ADDR_W = 32;
    localparam int HOP_W  = 8;
    localparam int LEN_W  = $clog2(ADDR_W + 1);

    // One stored route: flag, length, prefix, next hop (msb to lsb)
    typedef struct packed {
        logic              valid;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] prefix;
        logic [HOP_W-1:0]  hop;
    } lpm_entry_t;

    localparam int ENTRY_W = $bits(lpm_entry_t);

    // Outcome of comparing one entry against an address
    typedef struct packed {
        logic              hit;
        logic [LEN_W-1:0]  len;
        logic [HOP_W-1:0]  hop;
    } lpm_cand_t;

    // Mask keeping the upper 'len' bits of an address
    function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[ADDR_W-1-i] = (LEN_W'(i) < len);
        end
        return m;
    endfunction

    function automatic logic len_in_range(input logic [LEN_W-1:0] len);
        return len <= LEN_W'(ADDR_W);
    endfunction

endpackage

// File: rtl/lpm_entry_cmp.sv
`timescale 1ns/1ps
module lpm_entry_cmp
    import lpm_pkg::*;
(
    input  lpm_entry_t         entry,
    input  logic [ADDR_W-1:0]  addr,
    output lpm_cand_t          cand
);

    logic [ADDR_W-1:0] care;
    logic              bits_equal;

    always_comb begin
        care       = len_mask(entry.len);
        bits_equal = ((entry.prefix ^ addr) & care) == '0;
        cand.hit   = entry.valid && len_in_range(entry.len) && bits_equal;
        cand.len   = entry.len;
        cand.hop   = entry.hop;
    end

endmodule

// File: rtl/lpm_longest_sel.sv
`timescale 1ns/1ps
module lpm_longest_sel
    import lpm_pkg::*;
#(
    parameter int N = 4
) (
    input  lpm_cand_t [N-1:0] cands,
    output lpm_cand_t         best
);

    // Scan upward; a later candidate replaces only on a strictly longer
    // length, so the lowest index keeps ties.
    always_comb begin
        best = cands[0];
        for (int i = 1; i < N; i++) begin
            if (cands[i].hit && (!best.hit || cands[i].len > best.len)) begin
                best = cands[i];
            end
        end
    end

endmodule

// File: rtl/lpm_result_merge.sv
`timescale 1ns/1ps
module lpm_result_merge
    import lpm_pkg::*;
#(
    parameter logic [HOP_W-1:0] DEFAULT_HOP = '1
) (
    input  lpm_cand_t tbl,
    input  lpm_cand_t vic,
    output lpm_cand_t result
);

    always_comb begin
        if (vic.hit && (!tbl.hit || vic.len >= tbl.len)) begin
            result = vic;
        end else if (tbl.hit) begin
            result = tbl;
        end else begin
            result.hit = 1'b0;
            result.len = '0;
            result.hop = DEFAULT_HOP;
        end
    end

endmodule

// File: rtl/lpm_lookup_engine.sv
`timescale 1ns/1ps
module lpm_lookup_engine
    import lpm_pkg::*;
#(
    parameter int               ROW_BITS    = 10,
    parameter int               WAYS        = 4,
    parameter int               VICTIMS     = 8,
    parameter logic [HOP_W-1:0] DEFAULT_HOP = '1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [ROW_BITS-1:0]         req_row,
    output logic                        mem_rd_en,
    output logic [ROW_BITS-1:0]         mem_rd_row,
    input  logic [WAYS*ENTRY_W-1:0]     mem_rd_data,
    input  logic [VICTIMS*ENTRY_W-1:0]  victim_entries,
    output logic                        res_valid,
    output logic                        res_hit,
    output logic [LEN_W-1:0]            res_len,
    output logic [HOP_W-1:0]            res_hop
);

    // Stage 1: index (drives the memory address)
    logic                s1_valid;
    logic [ADDR_W-1:0]   s1_addr;
    logic [ROW_BITS-1:0] s1_row;

    // Stage 2: read (address aligned with returning row data)
    logic                s2_valid;
    logic [ADDR_W-1:0]   s2_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_addr  <= '0;
            s1_row   <= '0;
            s2_valid <= 1'b0;
            s2_addr  <= '0;
        end else begin
            s1_valid <= req_valid;
            s1_addr  <= req_addr;
            s1_row   <= req_row;
            s2_valid <= s1_valid;
            s2_addr  <= s1_addr;
        end
    end

    assign mem_rd_en  = s1_valid;
    assign mem_rd_row = s1_row;

    // Stage 3: compare and select
    lpm_cand_t [WAYS-1:0]    way_cand;
    lpm_cand_t [VICTIMS-1:0] vic_cand;
    lpm_cand_t               tbl_best;
    lpm_cand_t               vic_best;
    lpm_cand_t               merged;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        lpm_entry_cmp u_cmp (
            .entry (lpm_entry_t'(mem_rd_data[g*ENTRY_W +: ENTRY_W])),
            .addr  (s2_addr),
            .cand  (way_cand[g])
        );
    end

    for (genvar v = 0; v < VICTIMS; v++) begin : g_vic
        lpm_entry_cmp u_cmp (
            .entry (lpm_entry_t'(victim_entries[v*ENTRY_W +: ENTRY_W])),
            .addr  (s2_addr),
            .cand  (vic_cand[v])
        );
    end

    lpm_longest_sel #(.N(WAYS)) u_way_sel (
        .cands (way_cand),
        .best  (tbl_best)
    );

    lpm_longest_sel #(.N(VICTIMS)) u_vic_sel (
        .cands (vic_cand),
        .best  (vic_best)
    );

    lpm_result_merge #(.DEFAULT_HOP(DEFAULT_HOP)) u_merge (
        .tbl    (tbl_best),
        .vic    (vic_best),
        .result (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_len   <= '0;
            res_hop   <= DEFAULT_HOP;
        end else begin
            res_valid <= s2_valid;
            if (s2_valid) begin
                res_hit <= merged.hit;
                res_len <= merged.len;
                res_hop <= merged.hop;
            end else begin
                res_hit <= 1'b0;
                res_len <= '0;
                res_hop <= DEFAULT_HOP;
            end
        end
    end

endmodule

// File: rtl/lpm_lookup_checker.sv
`timescale 1ns/1ps
module lpm_lookup_checker
    import lpm_pkg::*;
#(
    parameter int               ROW_BITS    = 10,
    parameter logic [HOP_W-1:0] DEFAULT_HOP = '1
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [ROW_BITS-1:0] req_row,
    input logic                mem_rd_en,
    input logic [ROW_BITS-1:0] mem_rd_row,
    input logic                res_valid,
    input logic                res_hit,
    input logic [LEN_W-1:0]    res_len,
    input logic [HOP_W-1:0]    res_hop
);

    // Counts clean edges since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_hit && !mem_rd_en)); // R1

    AST_READ_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0) |-> (mem_rd_en == $past(req_valid))); // R2

    AST_READ_ROW: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_rd_row == $past(req_row))); // R2

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (res_valid == $past(req_valid, 3))); // R2

    AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_hop == DEFAULT_HOP && res_len == '0)); // R8

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_len <= LEN_W'(ADDR_W))); // R9

endmodule

bind lpm_lookup_engine lpm_lookup_checker #(
    .ROW_BITS    (ROW_BITS),
    .DEFAULT_HOP (DEFAULT_HOP)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_row    (req_row),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_row (mem_rd_row),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_len    (res_len),
    .res_hop    (res_hop)
);

// File: tb/lpm_lookup_engine_tb_top.sv
`timescale 1ns/1ps
module lpm_lookup_engine_tb_top;

    localparam int RB    = 3;
    localparam int NROW  = 8;
    localparam int NW    = 4;
    localparam int NV    = 3;
    localparam int EW    = 47;          // R3 entry width
    localparam logic [7:0] DEF = 8'hEE;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic [31:0]        req_addr = '0;
    logic [RB-1:0]      req_row = '0;
    logic               mem_rd_en;
    logic [RB-1:0]      mem_rd_row;
    logic [NW*EW-1:0]   mem_rd_data = '0;
    logic [NV*EW-1:0]   victim_entries = '0;
    logic               res_valid;
    logic               res_hit;
    logic [5:0]         res_len;
    logic [7:0]         res_hop;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    // Bench copy of the table and victim contents
    logic        tv [NROW][NW];
    logic [5:0]  tl [NROW][NW];
    logic [31:0] tp [NROW][NW];
    logic [7:0]  th [NROW][NW];
    logic        vv [NV];
    logic [5:0]  vl [NV];
    logic [31:0] vp [NV];
    logic [7:0]  vh [NV];

    always #2 clk = ~clk;

    lpm_lookup_engine #(
        .ROW_BITS(RB), .WAYS(NW), .VICTIMS(NV), .DEFAULT_HOP(DEF)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_row(req_row), .mem_rd_en(mem_rd_en), .mem_rd_row(mem_rd_row),
        .mem_rd_data(mem_rd_data), .victim_entries(victim_entries),
        .res_valid(res_valid), .res_hit(res_hit), .res_len(res_len),
        .res_hop(res_hop)
    );

    function automatic logic [NW*EW-1:0] pack_row(int r);
        logic [NW*EW-1:0] b;
        for (int w = 0; w < NW; w++) b[w*EW +: EW] = {tv[r][w], tl[r][w], tp[r][w], th[r][w]};
        return b;
    endfunction

    // Synchronous table memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= pack_row(int'(mem_rd_row));
    end

    task automatic sync_victims();
        for (int v = 0; v < NV; v++) victim_entries[v*EW +: EW] = {vv[v], vl[v], vp[v], vh[v]};
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed ^ (seed >> 15);
    endfunction

    function automatic bit hits(logic v, logic [5:0] len, logic [31:0] p, logic [31:0] a);
        int sh;
        if (!v || len > 6'd32) return 1'b0;
        sh = 32 - int'(len);
        return (a >> sh) == (p >> sh);
    endfunction

    // Expected {hit, len, hop} from the requirement rules
    function automatic logic [14:0] model(logic [31:0] a, int r);
        bit tbh = 0, vbh = 0;
        logic [5:0] tbl = 0, vbl = 0;
        logic [7:0] tbo = 0, vbo = 0;
        for (int w = 0; w < NW; w++)
            if (hits(tv[r][w], tl[r][w], tp[r][w], a) && (!tbh || tl[r][w] > tbl)) begin
                tbh = 1; tbl = tl[r][w]; tbo = th[r][w];
            end
        for (int v = 0; v < NV; v++)
            if (hits(vv[v], vl[v], vp[v], a) && (!vbh || vl[v] > vbl)) begin
                vbh = 1; vbl = vl[v]; vbo = vh[v];
            end
        if (vbh && (!tbh || vbl >= tbl)) return {1'b1, vbl, vbo};
        if (tbh) return {1'b1, tbl, tbo};
        return {1'b0, 6'd0, DEF};
    endfunction

    task automatic chk(bit ok, string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic clear_all();
        for (int r = 0; r < NROW; r++)
            for (int w = 0; w < NW; w++) begin
                tv[r][w] = 0; tl[r][w] = 0; tp[r][w] = 0; th[r][w] = 0;
            end
        for (int v = 0; v < NV; v++) begin
            vv[v] = 0; vl[v] = 0; vp[v] = 0; vh[v] = 0;
        end
        sync_victims();
    endtask

    // One isolated lookup with explicit expected values
    task automatic one_lookup(logic [31:0] a, int r, logic eh, logic [5:0] el,
                              logic [7:0] eo, string tag);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_row = RB'(r);
        @(negedge clk);
        req_valid = 0;
        chk(mem_rd_en && mem_rd_row == RB'(r),
            $sformatf("R2 read strobe: en=%0b row=%0d expected en=1 row=%0d", mem_rd_en, mem_rd_row, r));
        @(negedge clk);
        chk(!res_valid, $sformatf("R2 early result: res_valid=%0b expected 0", res_valid));
        @(negedge clk);
        chk(res_valid && {res_hit, res_len, res_hop} == {eh, el, eo},
            $sformatf("%s addr=%h: valid=%0b hit=%0b len=%0d hop=%h expected valid=1 hit=%0b len=%0d hop=%h",
                      tag, a, res_valid, res_hit, res_len, res_hop, eh, el, eo));
        @(negedge clk);
        chk(!res_valid, $sformatf("R2 single pulse: res_valid=%0b expected 0", res_valid));
    endtask

    task automatic fill_random();
        for (int r = 0; r < NROW; r++)
            for (int w = 0; w < NW; w++) begin
                tv[r][w] = (rnd() % 6) != 0;
                tl[r][w] = 6'(rnd() % 36);
                tp[r][w] = rnd();
                th[r][w] = 8'(rnd());
            end
        for (int v = 0; v < NV; v++) begin
            int sr, sw;
            sr = int'(rnd() % NROW); sw = int'(rnd() % NW);
            vv[v] = (rnd() % 3) != 0;
            vp[v] = tp[sr][sw];
            vl[v] = (rnd() % 2 == 0) ? tl[sr][sw] : 6'(rnd() % 34);
            vh[v] = 8'(rnd());
        end
        sync_victims();
    endtask

    // Back-to-back stream with bubbles; results compared three cycles on
    task automatic run_stream(int n);
        bit          dv [3];
        logic [14:0] de [3];
        int          issued = 0, seen = 0;
        for (int k = 0; k < 3; k++) begin dv[k] = 0; de[k] = 0; end
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            chk(res_valid == dv[2], $sformatf("R2 stream valid: res_valid=%0b expected %0b", res_valid, dv[2]));
            if (res_valid) seen++;
            if (dv[2])
                chk({res_hit, res_len, res_hop} == de[2],
                    $sformatf("R4 R5 R6 R7 R8 R9 stream result: hit=%0b len=%0d hop=%h expected hit=%0b len=%0d hop=%h",
                              res_hit, res_len, res_hop, de[2][14], de[2][13:8], de[2][7:0]));
            dv[2] = dv[1]; de[2] = de[1];
            dv[1] = dv[0]; de[1] = de[0];
            if (i < n && (rnd() % 5) != 0) begin
                int r, w, c;
                logic [31:0] base, hm;
                r = int'(rnd() % NROW); w = int'(rnd() % NW);
                base = (rnd() % 4 == 0) ? vp[rnd() % NV] : tp[r][w];
                c = int'(rnd() % 33);
                hm = (c == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - c));
                req_addr = (base & hm) | (rnd() & ~hm);
                req_row = RB'(r);
                req_valid = 1;
                dv[0] = 1; de[0] = model(req_addr, r);
                issued++;
            end else begin
                req_valid = 0;
                dv[0] = 0;
            end
        end
        req_valid = 0;
        chk(seen == issued, $sformatf("R2 result count: %0d expected %0d", seen, issued));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog: done=0 expected 1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        chk(!res_valid && !res_hit && !mem_rd_en,
            $sformatf("R1 in reset: valid=%0b hit=%0b rd_en=%0b expected 0 0 0", res_valid, res_hit, mem_rd_en));
        rst = 0;
        @(negedge clk);
        chk(!res_valid && !res_hit && !mem_rd_en,
            $sformatf("R1 after reset: valid=%0b hit=%0b rd_en=%0b expected 0 0 0", res_valid, res_hit, mem_rd_en));

        // Directed row 2
        tv[2][0] = 1; tl[2][0] = 8;  tp[2][0] = 32'h0A00_0000; th[2][0] = 8'h01;
        tv[2][1] = 1; tl[2][1] = 16; tp[2][1] = 32'h0A0B_FFFF; th[2][1] = 8'h02;
        tv[2][2] = 1; tl[2][2] = 16; tp[2][2] = 32'h0A0B_0000; th[2][2] = 8'h03;
        tv[2][3] = 0; tl[2][3] = 32; tp[2][3] = 32'h0A0B_0C0D; th[2][3] = 8'h04;
        one_lookup(32'h0A0B_0C0D, 2, 1, 16, 8'h02, "R5 R4 R3 tie lowest way, dont-care bits");
        one_lookup(32'h0A0C_0000, 2, 1, 8, 8'h01, "R4 length mask");
        tv[2][3] = 1; tl[2][3] = 40;
        one_lookup(32'h0A0B_0C0D, 2, 1, 16, 8'h02, "R9 length above 32 ignored");
        tv[2][3] = 0; tl[2][3] = 32;
        one_lookup(32'h0A0B_0C0D, 2, 1, 16, 8'h02, "R9 invalid flag ignored");
        one_lookup(32'hC000_0000, 2, 0, 0, DEF, "R8 miss default");
        vv[0] = 1; vl[0] = 16; vp[0] = 32'h0A0B_0000; vh[0] = 8'h09; sync_victims();
        one_lookup(32'h0A0B_0C0D, 2, 1, 16, 8'h09, "R7 victim wins tie");
        vv[1] = 1; vl[1] = 20; vp[1] = 32'h0A0B_0000; vh[1] = 8'h05;
        vv[2] = 1; vl[2] = 24; vp[2] = 32'h0A0B_0CFF; vh[2] = 8'h07; sync_victims();
        one_lookup(32'h0A0B_0C0D, 2, 1, 24, 8'h07, "R6 longer victim wins");
        one_lookup(32'h0A0B_0C0D, 5, 1, 24, 8'h07, "R6 victim alone on empty row");
        tl[2][0] = 0;
        one_lookup(32'hC000_0000, 2, 1, 0, 8'h01, "R10 zero-length default route");

        for (int p = 0; p < 4; p++) begin
            fill_random();
            run_stream(700);
            repeat (2) @(negedge clk);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule